// File: doc/BRIEF.md
# Phase-Matched Multi-Bank Clock Divider

One input clock feeds four output banks. Each bank has a two-bit ratio code that picks pass-through, divide-by-2 or divide-by-4. An active-low master reset pulls every output low at once, with or without a clock. After release, a two-flop synchroniser and then a four-cycle hold keep the dividers idle. Then every bank starts from the same phase, and their rising edges line up.

Ratio codes and enables are sampled on every rising input edge. They are only put into use at a common four-cycle boundary, when every output is low. This is why a bank never emits a shortened pulse. If the input clock stops, the outputs hold their levels and do not toggle.

Timing terms used below: cycle 0 starts at the 7th rising input edge after reset release. Each later rising edge starts the next cycle, numbered k. The high phase of a cycle is the time while the input is high, and the low phase is the rest of the cycle.

Top module: `clkdiv_fanout`

## Requirements
- R1: Bank b takes its ratio code from `ratio_sel[2b+1:2b]`. Code 00 is pass-through, 01 is divide-by-2, and 10 and 11 are both divide-by-4. Each bank uses its own code, independently of the others.
- R2: Rising edges of all enabled banks line up. Every divide-by-4 rise happens at the start of a cycle where every divide-by-2 bank and every pass-through bank also rises.
- R3: While `rst_n` is low, every output is low. Pulling `rst_n` low forces all outputs low within 1 ns, with no input edge needed.
- R4: After `rst_n` rises, all outputs stay low through the first six rising input edges. At the 7th rising edge (cycle 0), every enabled bank goes high together.
- R5: A ratio code change that is first sampled at the edge starting cycle j takes effect from cycle c. Cycle c is the smallest multiple of 4 that is greater than j. Before cycle c the bank keeps its old ratio.
- R6: An enable change follows the same rule as R5. A disabled bank holds its output low.
- R7: In pass-through mode, an enabled bank is high in the high phase of each cycle and low in the low phase.
- R8: If the input clock stops low, no output changes level for as long as the clock is stopped.
- R9: Divide-by-2 is high for the whole of every cycle with even k. Divide-by-4 is high for the whole of every cycle with k mod 4 equal to 0 or 1. These pulses are never shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| ratio_sel | input | 2*NBANK | Ratio code for each bank, two bits per bank |
| bank_en | input | NBANK | Enable for each bank |
| clk_out | output | NBANK | Bank output clocks |

## Verification
The enable of one bank and the ratio code of another are changed between the same two edges. Both are then put into use at the same four-cycle boundary. The bench models the moment each change takes effect and checks every bank in both phases of every cycle, before and after that boundary. A second collision comes from asserting master reset while a pass-through output is high. Reset must win immediately, without an edge, and the whole release hold must then start again.

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
  parameter int NBANK       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic [2*NBANK-1:0] ratio_sel,
  input  logic [NBANK-1:0]   bank_en,
  output logic [NBANK-1:0]   clk_out
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hold_cnt;
  logic                   run;
  logic [1:0]             phase;
  logic [2*NBANK-1:0]     sel_q;
  logic [NBANK-1:0]       en_q;
  logic [2*NBANK-1:0]     mode_c;
  logic [NBANK-1:0]       en_c;
  logic                   commit;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) begin
      hold_cnt <= '0;
      run      <= 1'b0;
    end else if (sync_q[SYNC_STAGES-1] && !run) begin
      if (hold_cnt == HW'(HOLD_CYCLES - 1)) run <= 1'b1;
      hold_cnt <= hold_cnt + 1'b1;
    end

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n)   phase <= 2'd0;
    else if (run) phase <= phase + 2'd1;
    else          phase <= 2'd0;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
    end else begin
      sel_q <= ratio_sel;
      en_q  <= bank_en;
    end

  assign commit = (phase == 2'd0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [1:0] mode_b, sel_nx;
    logic       en_b, en_nx, gate_b, div_b;

    assign sel_nx = commit ? sel_q[2*b +: 2] : mode_b;
    assign en_nx  = commit ? en_q[b] : en_b;

    always_ff @(negedge clk_in or negedge rst_n)
      if (!rst_n) begin
        mode_b <= 2'b00;
        en_b   <= 1'b0;
        gate_b <= 1'b0;
      end else begin
        mode_b <= sel_nx;
        en_b   <= en_nx;
        gate_b <= run && en_nx && (sel_nx == 2'b00);
      end

    always_ff @(posedge clk_in or negedge rst_n)
      if (!rst_n)              div_b <= 1'b0;
      else if (!run || !en_b)  div_b <= 1'b0;
      else begin
        case (mode_b)
          2'b00:   div_b <= 1'b0;
          2'b01:   div_b <= ~phase[0];
          default: div_b <= ~phase[1];
        endcase
      end

    assign mode_c[2*b +: 2] = mode_b;
    assign en_c[b]          = en_b;
    assign clk_out[b]       = div_b | (clk_in & gate_b);
  end
endmodule

// File: rtl/clkdiv_fanout_chk.sv
module clkdiv_fanout_chk #(
  parameter int NBANK       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input logic               clk_in,
  input logic               rst_n,
  input logic [NBANK-1:0]   clk_out,
  input logic               run,
  input logic [2*NBANK-1:0] mode_c,
  input logic [NBANK-1:0]   en_c
);
  localparam int LIM = SYNC_STAGES + HOLD_CYCLES + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0]    rel_cnt;
  logic [NBANK-1:0] ok2, ok4;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n)                  rel_cnt <= '0;
    else if (rel_cnt != CW'(LIM)) rel_cnt <= rel_cnt + 1'b1;

  for (genvar i = 0; i < NBANK; i++) begin : g_ok
    assign ok2[i] = run && en_c[i] && (mode_c[2*i +: 2] == 2'b01);
    assign ok4[i] = run && en_c[i] && mode_c[2*i+1];
  end

  // R3
  reset_low_chk: assert property (@(posedge clk_in) disable iff (rst_n)
    clk_out == '0);

  // R4
  hold_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (rel_cnt <= CW'(SYNC_STAGES + HOLD_CYCLES)) |-> (clk_out == '0));

  // R4
  hold_start_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (rel_cnt < CW'(SYNC_STAGES + HOLD_CYCLES)) |-> !run);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank_chk
    // R9
    half_toggle_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      ($past(ok2[i]) && $past(ok2[i], 2)) |-> (clk_out[i] != $past(clk_out[i])));

    // R6
    disabled_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      $past(!en_c[i]) |-> !clk_out[i]);

    for (genvar j = 0; j < NBANK; j++) begin : g_pair
      if (i != j) begin : g_ne
        // R2
        phase_align_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
          ($past(ok4[i]) && $past(ok2[j]) && clk_out[i] && !$past(clk_out[i]))
            |-> clk_out[j]);
      end
    end
  end
endmodule

bind clkdiv_fanout clkdiv_fanout_chk #(
  .NBANK(NBANK), .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)
) chk_i (
  .clk_in(clk_in), .rst_n(rst_n), .clk_out(clk_out),
  .run(run), .mode_c(mode_c), .en_c(en_c)
);

// File: tb/clkdiv_fanout_tb_top.sv
module clkdiv_fanout_tb_top;
  localparam int NB = 4;

  logic          clk_in = 1'b0;
  logic          clk_run = 1'b1;
  logic          rst_n = 1'b1;
  logic [2*NB-1:0] ratio_sel = '0;
  logic [NB-1:0]   bank_en = '0;
  logic [NB-1:0]   clk_out;

  int total = 0, fails = 0, k = 0;
  bit done = 0;
  logic [2*NB-1:0] eff_sel, lat_sel;
  logic [NB-1:0]   eff_en, lat_en;

  clkdiv_fanout dut_i (
    .clk_in(clk_in), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .bank_en(bank_en), .clk_out(clk_out)
  );

  initial forever begin
    #5;
    if (clk_run) clk_in = ~clk_in;
  end

  task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (k=%0d)", tag, act, exp, k);
    end
  endtask

  function automatic logic exp_bit(input logic [1:0] m, input logic e, input int kk, input bit hi);
    if (!e) return 1'b0;
    case (m)
      2'b00:   return hi;
      2'b01:   return (kk % 2) == 0;
      default: return (kk % 4) < 2;
    endcase
  endfunction

  function automatic logic [NB-1:0] exp_vec(input bit hi);
    logic [NB-1:0] v;
    for (int b = 0; b < NB; b++) v[b] = exp_bit(eff_sel[2*b +: 2], eff_en[b], k, hi);
    return v;
  endfunction

  task automatic cyc(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_in); #2;
      lat_sel = ratio_sel;
      lat_en  = bank_en;
      chk(tag, clk_out, exp_vec(1'b1));
      @(negedge clk_in); #2;
      chk(tag, clk_out, exp_vec(1'b0));
      if (k % 4 == 3) begin
        eff_sel = lat_sel;
        eff_en  = lat_en;
      end
      k++;
    end
  endtask

  task automatic release_and_hold();
    @(negedge clk_in); #2;
    rst_n = 1'b1;
    for (int e = 1; e <= 6; e++) begin
      @(posedge clk_in); #2;
      chk("R4 hold", clk_out, '0);
    end
    k = 0;
    eff_sel = ratio_sel;
    eff_en  = bank_en;
    @(negedge clk_in); #2;
  endtask

  task automatic t_reset_state();
    #1 rst_n = 1'b0;
    ratio_sel = {2'b11, 2'b10, 2'b01, 2'b00};
    bank_en   = 4'b1111;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_in); #2; chk("R3 reset high phase", clk_out, '0);
      @(negedge clk_in); #2; chk("R3 reset low phase", clk_out, '0);
    end
  endtask

  task automatic t_start_ratios();
    release_and_hold();
    @(posedge clk_in); #2;
    chk("R4 first edge", clk_out, 4'b1111);
    @(negedge clk_in); #2;
    k = 1;
    cyc("R1 R2 R7 R9 mixed ratios", 12);
  endtask

  task automatic t_ratio_change();
    while (k % 4 != 1) cyc("R5 align", 1);
    ratio_sel = {2'b11, 2'b01, 2'b00, 2'b01};
    cyc("R5 ratio change", 12);
  endtask

  task automatic t_enable_collide();
    while (k % 4 != 2) cyc("R6 align", 1);
    bank_en   = 4'b0111;
    ratio_sel = {2'b11, 2'b10, 2'b00, 2'b01};
    cyc("R6 R5 enable and ratio same boundary", 10);
    bank_en = 4'b1111;
    cyc("R6 re-enable", 8);
  endtask

  task automatic t_clock_stop();
    logic [NB-1:0] snap;
    snap = clk_out;
    clk_run = 1'b0;
    for (int i = 0; i < 12; i++) begin
      #7;
      chk("R8 stopped clock", clk_out, snap);
    end
    clk_run = 1'b1;
    cyc("R8 resume", 4);
  endtask

  task automatic t_async_reset();
    while (!(eff_sel[3:2] == 2'b00 && eff_en[1])) cyc("R3 align", 1);
    @(posedge clk_in); #2;
    chk("R3 pre-reset pass-through high", clk_out & 4'b0010, 4'b0010);
    rst_n = 1'b0;
    #1;
    chk("R3 async reset without edge", clk_out, '0);
    @(negedge clk_in); #2;
    chk("R3 in reset", clk_out, '0);
    release_and_hold();
    cyc("R4 restart after reset", 8);
  endtask

  initial begin
    t_reset_state();
    t_start_ratios();
    t_ratio_change();
    t_enable_collide();
    t_clock_stop();
    t_async_reset();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R4 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule